// File: doc/BRIEF.md
# Flip-mode output formatter self-test

This block is a built-in self-test for the path that reads a frame buffer and formats the pixels for a display driver. It scans a 160 x 60 test image that is already held in the frame buffer. It does this four times, each time with a different mirror setting. For every setting it produces the readout addresses, takes the returned pixels through a formatting register stage, and computes a CRC over the formatted stream. It then compares that CRC with an expected value supplied for that setting.

The test can start on its own when reset is released, or it can start on a request that arrives while the system is in standby. All four settings always run to completion. The block then reports:
- a pass bit for each setting,
- a fail bit for each setting,
- an overall verdict.

A failing run produces a single error-log strobe. It also keeps the display-enable output low, whatever the host asks for, until a later run passes. The frame buffer is outside the block. It must return the pixel for an address on the clock edge after that address is presented.

Top module: `fmt_bist_top`

## Requirements
- R1: Each setting presents exactly 160 x 60 addresses with `rd_valid` high. They come in raster order: lines form the outer loop and columns the inner loop. Every line starts at its leftmost read column, which is 159 when the horizontal mirror is on and 0 otherwise.
- R2: The horizontal mirror makes columns run from 159 down to 0. The vertical mirror makes lines run from 59 down to 0. Without a mirror, the count runs upward from 0.
- R3: Settings run in index order 0 to 3. Index bit 0 selects the horizontal mirror and index bit 1 selects the vertical mirror, so the order is: none, horizontal only, vertical only, both.
- R4: The CRC for a setting uses the formatted pixels only, which are the `rd_data` values that come out on `fmt_data` two cycles after their address. The polynomial is 0x04C11DB7 and the register starts at all ones. Each 16-bit pixel is shifted in MSB first. There is no reflection and no final XOR.
- R5: The CRC of setting k is compared with `exp_crc[32*k +: 32]`. The result is shown on `cfg_pass[k]` (match) or `cfg_fail[k]` (mismatch).
- R6: Starting a run clears every result flag. At the end of the run, `test_pass` is set only if all four settings match; otherwise `test_fail` is set.
- R7: `err_log` pulses high for exactly one cycle when a run ends with a failure. It stays low when a run passes.
- R8: A run starts once after reset release if `run_at_boot` is high. Later runs start on `start_req` only while `standby` is high and no run is in progress. In any other case `start_req` has no effect.
- R9: `disp_en` is high only when `disp_req` is high, the most recent completed run passed, and no run is in progress. It is low from reset until a run passes.
- R10: `fmt_sof` is high for one cycle on the first formatted pixel of each setting. The CRC is reset and begins accumulating only at that marker.
- R11: `busy` is high from the start of a run until its final compare. Read addresses are issued only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_at_boot | input | 1 | Start one run automatically after reset release |
| standby | input | 1 | Qualifier that allows start requests |
| start_req | input | 1 | Request to start a run |
| disp_req | input | 1 | Host request for display mode |
| exp_crc | input | 128 | Four expected CRCs; setting k uses bits [32k+31:32k] |
| rd_data | input | 16 | Frame-buffer pixel for the address of the previous cycle |
| rd_valid | output | 1 | Read address valid |
| rd_col | output | 8 | Read column, with the mirror applied |
| rd_line | output | 6 | Read line, with the mirror applied |
| fmt_valid | output | 1 | Formatted pixel valid |
| fmt_sof | output | 1 | Start-of-frame marker on the formatted stream |
| fmt_data | output | 16 | Formatted pixel |
| busy | output | 1 | Run in progress |
| cfg_pass | output | 4 | Per-setting match flags |
| cfg_fail | output | 4 | Per-setting mismatch flags |
| test_pass | output | 1 | All four settings matched |
| test_fail | output | 1 | At least one setting mismatched |
| err_log | output | 1 | One-cycle error-log event |
| disp_en | output | 1 | Display-mode grant |

## Verification
The bench uses a test image whose pixel values depend on both column and line. Because of this, a reversed step, a wrong edge value, or a swapped mirror bit shows up as an address mismatch and also shifts the CRC of that one setting.

In the failing run, the expected value is corrupted only for setting 2. A design that stops at the first mismatch, reuses the CRC from the previous setting, or indexes the expected values wrongly would report the wrong failure mask or skip addresses.

The bench also sends a start request while not in standby, and another one during a run. A design that honours either request would emit extra addresses or clear the result flags. Finally, it checks that a failure produces exactly one error strobe and keeps display mode blocked while the host is requesting it.

// File: rtl/fmt_bist_pkg.sv
package fmt_bist_pkg;
  localparam int unsigned NUM_CFG   = 4;
  localparam int unsigned CFG_IDX_W = 2;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bist_st_e;

  // setting index bit 0 = horizontal mirror, bit 1 = vertical mirror
  function automatic logic cfg_hmir(input logic [CFG_IDX_W-1:0] idx);
    return idx[0];
  endfunction

  function automatic logic cfg_vmir(input logic [CFG_IDX_W-1:0] idx);
    return idx[1];
  endfunction
endpackage

// File: rtl/fmt_bist_scan.sv
module fmt_bist_scan
  import fmt_bist_pkg::*;
#(
  parameter int unsigned IMG_W = 160,
  parameter int unsigned IMG_H = 60,
  localparam int unsigned COL_W  = $clog2(IMG_W),
  localparam int unsigned LINE_W = $clog2(IMG_H)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [CFG_IDX_W-1:0] go_cfg,
  output logic                 valid,
  output logic [COL_W-1:0]     col,
  output logic [LINE_W-1:0]    line,
  output logic                 first,
  output logic                 last
);
  localparam logic [COL_W-1:0]  COL_MAX  = COL_W'(IMG_W - 1);
  localparam logic [LINE_W-1:0] LINE_MAX = LINE_W'(IMG_H - 1);

  logic              act_q, act_d;
  logic [COL_W-1:0]  cnt_c_q, cnt_c_d;
  logic [LINE_W-1:0] cnt_l_q, cnt_l_d;
  logic              hm_q, hm_d, vm_q, vm_d;
  logic              end_col, end_line;

  assign end_col  = (cnt_c_q == COL_MAX);
  assign end_line = (cnt_l_q == LINE_MAX);

  always_comb begin
    act_d   = act_q;
    cnt_c_d = cnt_c_q;
    cnt_l_d = cnt_l_q;
    hm_d    = hm_q;
    vm_d    = vm_q;
    if (go) begin
      act_d   = 1'b1;
      cnt_c_d = '0;
      cnt_l_d = '0;
      hm_d    = cfg_hmir(go_cfg);
      vm_d    = cfg_vmir(go_cfg);
    end else if (act_q) begin
      if (end_col) begin
        cnt_c_d = '0;
        if (end_line) begin
          act_d = 1'b0;
        end else begin
          cnt_l_d = cnt_l_q + 1'b1;
        end
      end else begin
        cnt_c_d = cnt_c_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      cnt_c_q <= '0;
      cnt_l_q <= '0;
      hm_q    <= 1'b0;
      vm_q    <= 1'b0;
    end else begin
      act_q   <= act_d;
      cnt_c_q <= cnt_c_d;
      cnt_l_q <= cnt_l_d;
      hm_q    <= hm_d;
      vm_q    <= vm_d;
    end
  end

  assign valid = act_q;
  assign col   = hm_q ? (COL_MAX - cnt_c_q) : cnt_c_q;
  assign line  = vm_q ? (LINE_MAX - cnt_l_q) : cnt_l_q;
  assign first = act_q && (cnt_c_q == '0) && (cnt_l_q == '0);
  assign last  = act_q && end_col && end_line;
endmodule

// File: rtl/fmt_bist_fmt.sv
module fmt_bist_fmt #(
  parameter int unsigned PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_valid,
  input  logic             addr_first,
  input  logic             addr_last,
  input  logic [PIX_W-1:0] rd_data,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [PIX_W-1:0] out_data
);
  // stage 1 aligns the address tags with the returning read data
  logic v1_q, s1_q, e1_q;
  // stage 2 is the formatted output register
  logic             ov_q, os_q, oe_q;
  logic [PIX_W-1:0] od_q, od_d;

  always_comb begin
    od_d = od_q;
    if (v1_q) od_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      s1_q <= 1'b0;
      e1_q <= 1'b0;
      ov_q <= 1'b0;
      os_q <= 1'b0;
      oe_q <= 1'b0;
      od_q <= '0;
    end else begin
      v1_q <= addr_valid;
      s1_q <= addr_valid & addr_first;
      e1_q <= addr_valid & addr_last;
      ov_q <= v1_q;
      os_q <= v1_q & s1_q;
      oe_q <= v1_q & e1_q;
      od_q <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_sof   = os_q;
  assign out_eof   = oe_q;
  assign out_data  = od_q;
endmodule

// File: rtl/fmt_bist_crc.sv
module fmt_bist_crc #(
  parameter int unsigned       PIX_W    = 16,
  parameter int unsigned       CRC_W    = 32,
  parameter logic [CRC_W-1:0]  CRC_POLY = 32'h04C11DB7,
  parameter logic [CRC_W-1:0]  CRC_INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [PIX_W-1:0] in_data,
  output logic [CRC_W-1:0] crc,
  output logic             done
);
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] seed,
                                                input logic [PIX_W-1:0] word);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = seed;
    for (int b = PIX_W - 1; b >= 0; b--) begin
      fb = r[CRC_W-1] ^ word[b];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  logic [CRC_W-1:0] crc_q, crc_d;
  logic             armed_q, armed_d;
  logic             done_q, done_d;

  always_comb begin
    crc_d   = crc_q;
    armed_d = armed_q;
    done_d  = 1'b0;
    if (in_valid && in_sof) begin
      crc_d   = crc_step(CRC_INIT, in_data);
      armed_d = !in_eof;
      done_d  = in_eof;
    end else if (in_valid && armed_q) begin
      crc_d = crc_step(crc_q, in_data);
      if (in_eof) begin
        armed_d = 1'b0;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q   <= CRC_INIT;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      crc_q   <= crc_d;
      armed_q <= armed_d;
      done_q  <= done_d;
    end
  end

  assign crc  = crc_q;
  assign done = done_q;
endmodule

// File: rtl/fmt_bist_top.sv
module fmt_bist_top
  import fmt_bist_pkg::*;
#(
  parameter int unsigned      IMG_W    = 160,
  parameter int unsigned      IMG_H    = 60,
  parameter int unsigned      PIX_W    = 16,
  parameter int unsigned      CRC_W    = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7,
  localparam int unsigned COL_W  = $clog2(IMG_W),
  localparam int unsigned LINE_W = $clog2(IMG_H),
  localparam int unsigned EXP_W  = NUM_CFG * CRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_at_boot,
  input  logic               standby,
  input  logic               start_req,
  input  logic               disp_req,
  input  logic [EXP_W-1:0]   exp_crc,
  input  logic [PIX_W-1:0]   rd_data,
  output logic               rd_valid,
  output logic [COL_W-1:0]   rd_col,
  output logic [LINE_W-1:0]  rd_line,
  output logic               fmt_valid,
  output logic               fmt_sof,
  output logic [PIX_W-1:0]   fmt_data,
  output logic               busy,
  output logic [NUM_CFG-1:0] cfg_pass,
  output logic [NUM_CFG-1:0] cfg_fail,
  output logic               test_pass,
  output logic               test_fail,
  output logic               err_log,
  output logic               disp_en
);
  localparam logic [CFG_IDX_W-1:0] LAST_CFG = CFG_IDX_W'(NUM_CFG - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // sequencer state
  bist_st_e             st_q, st_d;
  logic [CFG_IDX_W-1:0] mode_q, mode_d;
  logic [NUM_CFG-1:0]   pass_q, pass_d, fail_q, fail_d;
  logic                 tp_q, tp_d, tf_q, tf_d;
  logic                 err_q, err_d;
  logic                 boot_q, boot_d;
  logic                 scan_go;
  logic [CFG_IDX_W-1:0] scan_cfg;
  logic                 launch;
  logic                 hit;

  // datapath links
  logic              sc_valid, sc_first, sc_last;
  logic [COL_W-1:0]  sc_col;
  logic [LINE_W-1:0] sc_line;
  logic              f_valid, f_sof, f_eof;
  logic [PIX_W-1:0]  f_data;
  logic [CRC_W-1:0]  crc_val;
  logic              crc_done;

  fmt_bist_scan #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_scan (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .go     (scan_go),
    .go_cfg (scan_cfg),
    .valid  (sc_valid),
    .col    (sc_col),
    .line   (sc_line),
    .first  (sc_first),
    .last   (sc_last)
  );

  fmt_bist_fmt #(.PIX_W(PIX_W)) u_fmt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .addr_valid (sc_valid),
    .addr_first (sc_first),
    .addr_last  (sc_last),
    .rd_data    (rd_data),
    .out_valid  (f_valid),
    .out_sof    (f_sof),
    .out_eof    (f_eof),
    .out_data   (f_data)
  );

  fmt_bist_crc #(.PIX_W(PIX_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .in_valid (f_valid),
    .in_sof   (f_sof),
    .in_eof   (f_eof),
    .in_data  (f_data),
    .crc      (crc_val),
    .done     (crc_done)
  );

  assign launch = (boot_q && run_at_boot) || (start_req && standby);
  assign hit    = (crc_val == exp_crc[int'(mode_q)*CRC_W +: CRC_W]);

  always_comb begin
    st_d     = st_q;
    mode_d   = mode_q;
    pass_d   = pass_q;
    fail_d   = fail_q;
    tp_d     = tp_q;
    tf_d     = tf_q;
    err_d    = 1'b0;
    boot_d   = boot_q;
    scan_go  = 1'b0;
    scan_cfg = mode_q;
    unique case (st_q)
      ST_IDLE: begin
        boot_d = 1'b0;
        if (launch) begin
          st_d     = ST_RUN;
          mode_d   = '0;
          pass_d   = '0;
          fail_d   = '0;
          tp_d     = 1'b0;
          tf_d     = 1'b0;
          scan_go  = 1'b1;
          scan_cfg = '0;
        end
      end
      ST_RUN: begin
        if (crc_done) begin
          pass_d[mode_q] = hit;
          fail_d[mode_q] = !hit;
          if (mode_q == LAST_CFG) begin
            st_d  = ST_IDLE;
            tp_d  = ~|fail_d;
            tf_d  = |fail_d;
            err_d = |fail_d;
          end else begin
            mode_d   = mode_q + 1'b1;
            scan_go  = 1'b1;
            scan_cfg = mode_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      pass_q <= '0;
      fail_q <= '0;
      tp_q   <= 1'b0;
      tf_q   <= 1'b0;
      err_q  <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      pass_q <= pass_d;
      fail_q <= fail_d;
      tp_q   <= tp_d;
      tf_q   <= tf_d;
      err_q  <= err_d;
      boot_q <= boot_d;
    end
  end

  assign rd_valid  = sc_valid;
  assign rd_col    = sc_col;
  assign rd_line   = sc_line;
  assign fmt_valid = f_valid;
  assign fmt_sof   = f_sof;
  assign fmt_data  = f_data;
  assign busy      = (st_q == ST_RUN);
  assign cfg_pass  = pass_q;
  assign cfg_fail  = fail_q;
  assign test_pass = tp_q;
  assign test_fail = tf_q;
  assign err_log   = err_q;
  assign disp_en   = disp_req && tp_q && (st_q == ST_IDLE);
endmodule

// File: rtl/fmt_bist_chk.sv
module fmt_bist_chk #(
  parameter int unsigned IMG_W = 160,
  parameter int unsigned IMG_H = 60,
  localparam int unsigned COL_W  = $clog2(IMG_W),
  localparam int unsigned LINE_W = $clog2(IMG_H)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic [COL_W-1:0]  rd_col,
  input logic [LINE_W-1:0] rd_line,
  input logic [1:0]        mode,
  input logic              busy,
  input logic              fmt_valid,
  input logic              fmt_sof,
  input logic              err_log,
  input logic              test_pass,
  input logic              test_fail,
  input logic              disp_en
);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(IMG_W - 1);

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (int'(rd_col) < IMG_W) && (int'(rd_line) < IMG_H)); // R1

  AST_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) && rd_line != $past(rd_line))
      |-> rd_col == (mode[0] ? COL_MAX : '0)); // R1

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) && rd_line == $past(rd_line))
      |-> rd_col == (mode[0] ? COL_W'($past(rd_col) - 1'b1)
                             : COL_W'($past(rd_col) + 1'b1))); // R2

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) && rd_line != $past(rd_line))
      |-> rd_line == (mode[1] ? LINE_W'($past(rd_line) - 1'b1)
                              : LINE_W'($past(rd_line) + 1'b1))); // R2

  AST_READ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy); // R11

  AST_SOF_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_sof |-> fmt_valid); // R10

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_log |=> !err_log); // R7

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_pass && test_fail)); // R6

  AST_FAIL_BLOCKS_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    (test_fail || busy) |-> !disp_en); // R9
endmodule

bind fmt_bist_top fmt_bist_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_valid  (rd_valid),
  .rd_col    (rd_col),
  .rd_line   (rd_line),
  .mode      (mode_q),
  .busy      (busy),
  .fmt_valid (fmt_valid),
  .fmt_sof   (fmt_sof),
  .err_log   (err_log),
  .test_pass (test_pass),
  .test_fail (test_fail),
  .disp_en   (disp_en)
);

// File: tb/fmt_bist_top_test.sv
module fmt_bist_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 160;
  localparam int H = 60;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic         clk = 1'b0;
  logic         rst_n, run_at_boot, standby, start_req, disp_req;
  logic [127:0] exp_crc;
  logic [15:0]  rd_data;
  logic         rd_valid, fmt_valid, fmt_sof, busy;
  logic [7:0]   rd_col;
  logic [5:0]   rd_line;
  logic [15:0]  fmt_data;
  logic [3:0]   cfg_pass, cfg_fail;
  logic         test_pass, test_fail, err_log, disp_en;

  int n_cmp = 0;
  int n_bad = 0;
  int err_cnt = 0;
  int sof_cnt = 0;
  int frame_pos = 0;
  bit finished = 0;
  int addr_q[$];
  logic [15:0] pix_q[$];
  logic [31:0] gold [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  fmt_bist_top uut (
    .clk(clk), .rst_n(rst_n), .run_at_boot(run_at_boot), .standby(standby),
    .start_req(start_req), .disp_req(disp_req), .exp_crc(exp_crc),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_col(rd_col), .rd_line(rd_line),
    .fmt_valid(fmt_valid), .fmt_sof(fmt_sof), .fmt_data(fmt_data), .busy(busy),
    .cfg_pass(cfg_pass), .cfg_fail(cfg_fail), .test_pass(test_pass),
    .test_fail(test_fail), .err_log(err_log), .disp_en(disp_en)
  );

  function automatic logic [15:0] pix(int c, int l);
    return 16'((c * 37 + l * 101 + c * l * 3) ^ (l * 512));
  endfunction

  function automatic logic [31:0] golden(int m);
    logic [31:0] r;
    logic [15:0] p;
    logic fb;
    r = '1;
    for (int li = 0; li < H; li++) begin
      for (int ci = 0; ci < W; ci++) begin
        p = pix(m[0] ? W - 1 - ci : ci, m[1] ? H - 1 - li : li);
        for (int b = 15; b >= 0; b--) begin
          fb = r[31] ^ p[b];
          r  = {r[30:0], 1'b0};
          if (fb) r = r ^ POLY;
        end
      end
    end
    return r;
  endfunction

  // frame buffer: registered read, one cycle latency
  always @(posedge clk) rd_data <= pix(int'(rd_col), int'(rd_line));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_run();
    for (int m = 0; m < 4; m++)
      for (int li = 0; li < H; li++)
        for (int ci = 0; ci < W; ci++)
          addr_q.push_back((m[0] ? W - 1 - ci : ci) + 256 * (m[1] ? H - 1 - li : li));
  endtask

  task automatic wait_run();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (addr_q.size() == 0) begin
          check(0, "R1 unexpected address", {rd_line, rd_col}, 0);
        end else begin
          int e;
          e = addr_q.pop_front();
          check(rd_col == 8'(e % 256), "R2 column", rd_col, e % 256);
          check(rd_line == 6'(e / 256), "R3 line order", rd_line, e / 256);
          pix_q.push_back(pix(e % 256, e / 256));
        end
        check(busy, "R11 read while idle", busy, 1);
      end
      if (fmt_valid) begin
        logic [15:0] ep;
        ep = (pix_q.size() != 0) ? pix_q.pop_front() : 16'h0;
        check(fmt_data == ep, "R4 formatted pixel", fmt_data, ep);
        check(fmt_sof == (frame_pos == 0), "R10 sof position", fmt_sof, frame_pos == 0);
        frame_pos = (frame_pos + 1) % (W * H);
      end
      if (fmt_sof) sof_cnt++;
      if (err_log) err_cnt++;
      if (disp_en) check(test_pass && !busy && disp_req, "R9 display grant", disp_en, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    for (int m = 0; m < 4; m++) gold[m] = golden(m);
    rst_n = 0; run_at_boot = 1; standby = 0; start_req = 0; disp_req = 1;
    exp_crc = {gold[3], gold[2], gold[1], gold[0]};
    repeat (3) @(negedge clk);
    check(!busy && !rd_valid, "R11 reset idle", busy, 0);
    check(cfg_pass == 0 && cfg_fail == 0, "R6 reset flags", {cfg_pass, cfg_fail}, 0);
    check(!test_pass && !test_fail, "R6 reset verdict", {test_pass, test_fail}, 0);
    check(!disp_en, "R9 blocked at reset", disp_en, 0);

    // boot run, all expected values correct
    push_run();
    rst_n = 1;
    wait_run();
    check(addr_q.size() == 0, "R1 address count", addr_q.size(), 0);
    check(cfg_pass == 4'b1111, "R5 pass mask", cfg_pass, 4'b1111);
    check(cfg_fail == 4'b0000, "R5 fail mask", cfg_fail, 0);
    check(test_pass && !test_fail, "R6 all match", {test_pass, test_fail}, 2'b10);
    check(err_cnt == 0, "R7 no error on pass", err_cnt, 0);
    check(disp_en, "R9 grant after pass", disp_en, 1);
    check(sof_cnt == 4, "R10 markers per run", sof_cnt, 4);

    // request outside standby must not start (boot already consumed)
    start_req = 1;
    @(negedge clk);
    start_req = 0;
    repeat (12) @(negedge clk);
    check(!busy, "R8 request without standby", busy, 0);
    check(test_pass && cfg_pass == 4'b1111, "R8 results untouched", cfg_pass, 4'b1111);

    // failing run: setting 2 expected value corrupted
    exp_crc[64 +: 32] = gold[2] ^ 32'h1;
    push_run();
    standby = 1;
    start_req = 1;
    @(negedge clk);
    start_req = 0;
    repeat (3) @(negedge clk);
    check(busy, "R11 busy during run", busy, 1);
    check(!test_pass && cfg_pass == 0, "R6 flags cleared at start", {test_pass, cfg_pass}, 0);
    start_req = 1;
    @(negedge clk);
    start_req = 0;
    wait_run();
    check(addr_q.size() == 0, "R8 no restart while busy", addr_q.size(), 0);
    check(cfg_fail == 4'b0100, "R5 fail mask", cfg_fail, 4'b0100);
    check(cfg_pass == 4'b1011, "R5 pass mask", cfg_pass, 4'b1011);
    check(test_fail && !test_pass, "R6 verdict fail", {test_pass, test_fail}, 2'b01);
    check(err_cnt == 1, "R7 one error strobe", err_cnt, 1);
    check(!disp_en && disp_req, "R9 display blocked", disp_en, 0);
    check(sof_cnt == 8, "R10 markers after two runs", sof_cnt, 8);
    summary();
  end
endmodule